// File: doc/BRIEF.md
# Memory Browser and Cycle-Count Panel Controller

This controller drives four hexadecimal digit positions on a front panel that sits beside a byte-array sorting engine. In browse mode the upper two digits show an 8-bit RAM address and the lower two digits show the byte stored there. Single-cycle up and down pulses from debounced buttons move the address through the 256-entry array, and the address wraps at both ends. A left-button pulse starts a fill. The fill writes a pseudorandom byte into every entry, from address zero upward, and then the controller returns to browsing.

A level input marks a sort in progress. While it is high every digit shows a dash. When it falls, the panel shows the number of cycles the sort took. Two switches choose which count is shown: the one from the software run or the one from the hardware run. They also choose whether the low or the high 16 bits of that 32-bit count appear. Any up, down or left pulse while a count is on display sends the panel back to browse mode, and the address is kept.

The block does not contain the RAM. It drives the address, write enable and write data of an external synchronous RAM with one cycle of read latency, and it reads that RAM's read data back. Each digit position is sent out as a 5-bit code for a separate digit driver to decode.

Top module: `panel_view_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the controller is in browse mode with address 0x00, `ram_we` is 0, and digits 3 and 2 both carry code 0x00.
- R2: Digit i occupies bits [5i+4:5i] of `digit_codes`, and codes 0x00 to 0x0F mean the hex value. In browse mode, digit 3 shows address bits 7:4, digit 2 shows address bits 3:0, digit 1 shows `ram_rdata` bits 7:4 and digit 0 shows `ram_rdata` bits 3:0. The data digits therefore follow a new address one cycle after it appears on `ram_addr`.
- R3: In browse mode, an up pulse adds one to the address and a down pulse subtracts one, both modulo 256, so 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF. An up pulse and a down pulse in the same cycle leave the address unchanged.
- R4: A left pulse in browse mode starts a fill of 256 consecutive cycles. In those cycles `ram_we` is 1 and `ram_addr` counts 0x00 to 0xFF in order. `ram_wdata` takes successive states of an 8-bit generator that starts at 0x01 after reset and steps as s -> (s >> 1) XOR (s[0] ? 0xB8 : 0x00). The generator's state carries over from one fill to the next. The cycle after the last write, the controller is back in browse mode.
- R5: During a fill every digit carries code 0x11 (blank). Up, down and sort-active inputs have no effect during a fill, and the browse address after the fill equals the address before it.
- R6: When `sort_active` is high in browse or count mode, the next cycle is sort mode, with every digit carrying code 0x10 (dash, middle segment only). This takes priority over up, down and left pulses in the same cycle. Buttons are ignored while sorting.
- R7: The cycle after `sort_active` falls in sort mode, the controller is in count mode. Digit i then shows bits [4i+3:4i] of the selected 16-bit count slice.
- R8: In count mode, `sel_hw_count`=0 selects `sw_cycles` and 1 selects `hw_cycles`. `sel_hi_half`=0 selects bits 15:0 and 1 selects bits 31:16. A switch change affects the digits in the same cycle.
- R9: In count mode, with `sort_active` low, an up, down or left pulse returns the controller to browse mode. The address is unchanged and no fill starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up | input | 1 | Single-cycle up pulse |
| btn_down | input | 1 | Single-cycle down pulse |
| btn_left | input | 1 | Single-cycle fill / exit pulse |
| sort_active | input | 1 | High while a sort runs |
| sel_hi_half | input | 1 | Count half select (0 low, 1 high) |
| sel_hw_count | input | 1 | Count source select (0 software, 1 hardware) |
| sw_cycles | input | 32 | Software sort cycle count |
| hw_cycles | input | 32 | Hardware sort cycle count |
| ram_rdata | input | 8 | RAM read data, one cycle after address |
| ram_addr | output | 8 | RAM address (fill pointer or browse address) |
| ram_we | output | 1 | RAM write enable during fill |
| ram_wdata | output | 8 | Pseudorandom fill byte |
| digit_codes | output | 20 | Four 5-bit digit codes, digit 0 in the low bits |

## Verification
Two kinds of event can arrive in the same cycle, and the bench drives both cases on purpose. In the first, a sort starts in the same cycle as a button pulse. The bench raises `sort_active` in the cycle an up pulse arrives and expects dashes with the address unchanged. In the second, a fill starts in the same cycle as a step: a left pulse arrives together with an up pulse. The bench expects the fill to win, so the address after the fill matches the address before it and the written bytes match the bench's own model of the generator. Up and down pulsing together, and up pulses or sort-active pulses during a fill, are judged by the address digits and the contents read back afterwards.

// File: rtl/panel_pkg.sv
package panel_pkg;

    typedef enum logic [1:0] {
        MODE_BROWSE = 2'd0,
        MODE_FILL   = 2'd1,
        MODE_SORT   = 2'd2,
        MODE_COUNT  = 2'd3
    } view_mode_e;

    localparam int CODE_W = 5;
    typedef logic [CODE_W-1:0] digit_code_t;

    localparam digit_code_t CODE_DASH  = 5'h10;
    localparam digit_code_t CODE_BLANK = 5'h11;

    typedef struct packed {
        logic up;
        logic down;
        logic left;
    } btn_pulse_t;

    typedef struct packed {
        logic step_en;
        logic fill_start;
    } mode_ctl_t;

    function automatic digit_code_t hex_code(input logic [3:0] nib);
        return {1'b0, nib};
    endfunction

    function automatic logic any_press(input btn_pulse_t b);
        return b.up | b.down | b.left;
    endfunction

endpackage

// File: rtl/panel_mode_fsm.sv
module panel_mode_fsm
    import panel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  btn_pulse_t btn,
    input  logic       sort_active,
    input  logic       fill_last,
    output view_mode_e mode,
    output mode_ctl_t  ctl
);

    view_mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        ctl    = '0;
        unique case (mode_q)
            MODE_BROWSE: begin
                if (sort_active) begin
                    mode_d = MODE_SORT;
                end else if (btn.left) begin
                    mode_d         = MODE_FILL;
                    ctl.fill_start = 1'b1;
                end else begin
                    ctl.step_en = 1'b1;
                end
            end
            MODE_FILL: begin
                if (fill_last) mode_d = MODE_BROWSE;
            end
            MODE_SORT: begin
                if (!sort_active) mode_d = MODE_COUNT;
            end
            MODE_COUNT: begin
                if (sort_active)         mode_d = MODE_SORT;
                else if (any_press(btn)) mode_d = MODE_BROWSE;
            end
            default: mode_d = MODE_BROWSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_BROWSE;
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;

endmodule

// File: rtl/panel_addr_step.sv
module panel_addr_step #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              inc,
    input  logic              dec,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (step_en) begin
            if (inc && !dec)      addr_q <= addr_q + 1'b1;
            else if (dec && !inc) addr_q <= addr_q - 1'b1;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/panel_fill_gen.sv
module panel_fill_gen #(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] SEED = 8'h01,
    parameter logic [DATA_W-1:0] TAPS = 8'hB8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    output logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] data,
    output logic              last
);

    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] state_q;
    logic [DATA_W-1:0] state_nxt;

    assign state_nxt = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            state_q <= SEED;
        end else if (start) begin
            ptr_q <= '0;
        end else if (active) begin
            ptr_q   <= ptr_q + 1'b1;
            state_q <= state_nxt;
        end
    end

    assign ptr  = ptr_q;
    assign data = state_q;
    assign last = active && (&ptr_q);

endmodule

// File: rtl/panel_digit_mux.sv
module panel_digit_mux
    import panel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 32,
    localparam int NUM_DIG = (ADDR_W + DATA_W) / 4,
    localparam int HALF_W  = CNT_W / 2
) (
    input  view_mode_e                  mode,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           rdata,
    input  logic [CNT_W-1:0]            sw_cnt,
    input  logic [CNT_W-1:0]            hw_cnt,
    input  logic                        sel_hi,
    input  logic                        sel_hw,
    output logic [NUM_DIG*CODE_W-1:0]   codes
);

    logic [ADDR_W+DATA_W-1:0] browse_word;
    logic [CNT_W-1:0]         cnt_sel;
    logic [HALF_W-1:0]        cnt_half;

    assign browse_word = {addr, rdata};
    assign cnt_sel     = sel_hw ? hw_cnt : sw_cnt;
    assign cnt_half    = sel_hi ? cnt_sel[CNT_W-1 -: HALF_W] : cnt_sel[HALF_W-1:0];

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_digit
        always_comb begin
            unique case (mode)
                MODE_BROWSE: codes[g*CODE_W +: CODE_W] = hex_code(browse_word[g*4 +: 4]);
                MODE_FILL:   codes[g*CODE_W +: CODE_W] = CODE_BLANK;
                MODE_SORT:   codes[g*CODE_W +: CODE_W] = CODE_DASH;
                MODE_COUNT:  codes[g*CODE_W +: CODE_W] = hex_code(cnt_half[g*4 +: 4]);
                default:     codes[g*CODE_W +: CODE_W] = CODE_BLANK;
            endcase
        end
    end

endmodule

// File: rtl/panel_view_ctrl.sv
module panel_view_ctrl
    import panel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 32,
    parameter logic [DATA_W-1:0] FILL_SEED = 8'h01,
    parameter logic [DATA_W-1:0] FILL_TAPS = 8'hB8,
    localparam int NUM_DIG = (ADDR_W + DATA_W) / 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      btn_up,
    input  logic                      btn_down,
    input  logic                      btn_left,
    input  logic                      sort_active,
    input  logic                      sel_hi_half,
    input  logic                      sel_hw_count,
    input  logic [CNT_W-1:0]          sw_cycles,
    input  logic [CNT_W-1:0]          hw_cycles,
    input  logic [DATA_W-1:0]         ram_rdata,
    output logic [ADDR_W-1:0]         ram_addr,
    output logic                      ram_we,
    output logic [DATA_W-1:0]         ram_wdata,
    output logic [NUM_DIG*CODE_W-1:0] digit_codes
);

    btn_pulse_t        btn;
    view_mode_e        mode_q;
    mode_ctl_t         ctl;
    logic              fill_last;
    logic [ADDR_W-1:0] browse_addr;
    logic [ADDR_W-1:0] fill_ptr;

    assign btn = '{up: btn_up, down: btn_down, left: btn_left};

    panel_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .btn         (btn),
        .sort_active (sort_active),
        .fill_last   (fill_last),
        .mode        (mode_q),
        .ctl         (ctl)
    );

    panel_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .clk     (clk),
        .rst     (rst),
        .step_en (ctl.step_en),
        .inc     (btn.up),
        .dec     (btn.down),
        .addr    (browse_addr)
    );

    panel_fill_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEED   (FILL_SEED),
        .TAPS   (FILL_TAPS)
    ) u_fill (
        .clk    (clk),
        .rst    (rst),
        .start  (ctl.fill_start),
        .active (mode_q == MODE_FILL),
        .ptr    (fill_ptr),
        .data   (ram_wdata),
        .last   (fill_last)
    );

    panel_digit_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_mux (
        .mode   (mode_q),
        .addr   (browse_addr),
        .rdata  (ram_rdata),
        .sw_cnt (sw_cycles),
        .hw_cnt (hw_cycles),
        .sel_hi (sel_hi_half),
        .sel_hw (sel_hw_count),
        .codes  (digit_codes)
    );

    assign ram_we   = (mode_q == MODE_FILL);
    assign ram_addr = ram_we ? fill_ptr : browse_addr;

endmodule

// File: rtl/panel_view_chk.sv
module panel_view_chk
    import panel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int NUM_DIG = (ADDR_W + DATA_W) / 4
) (
    input logic                      clk,
    input logic                      rst,
    input view_mode_e                mode,
    input logic                      btn_up,
    input logic                      btn_down,
    input logic                      btn_left,
    input logic                      sort_active,
    input logic [ADDR_W-1:0]         browse_addr,
    input logic                      ram_we,
    input logic [ADDR_W-1:0]         ram_addr,
    input logic [NUM_DIG*CODE_W-1:0] digit_codes
);

    // R4: fill writes land on consecutive addresses
    p_fill_order_r4: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |-> ram_addr == ADDR_W'($past(ram_addr) + 1'b1));

    // R5: blank digits and a frozen browse address during a fill
    p_fill_blank_r5: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> digit_codes == {NUM_DIG{CODE_BLANK}});
    p_fill_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> $stable(browse_addr));

    // R3: single-direction steps, modulo the address width
    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BROWSE && btn_up && !btn_down && !btn_left && !sort_active)
        |=> browse_addr == ADDR_W'($past(browse_addr) + 1'b1));
    p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BROWSE && btn_down && !btn_up && !btn_left && !sort_active)
        |=> browse_addr == ADDR_W'($past(browse_addr) - 1'b1));

    // R6: sort entry and dash display
    p_sort_enter_r6: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_FILL && sort_active) |=> mode == MODE_SORT);
    p_sort_dash_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SORT) |-> digit_codes == {NUM_DIG{CODE_DASH}});

    // R9: leaving the count view keeps the address and starts no fill
    p_count_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COUNT && !sort_active && (btn_up || btn_down || btn_left))
        |=> (mode == MODE_BROWSE && $stable(browse_addr) && !ram_we));

endmodule

bind panel_view_ctrl panel_view_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode_q),
    .btn_up      (btn_up),
    .btn_down    (btn_down),
    .btn_left    (btn_left),
    .sort_active (sort_active),
    .browse_addr (browse_addr),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .digit_codes (digit_codes)
);

// File: tb/tb_panel_view_ctrl.sv
module tb_panel_view_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        btn_up = 1'b0, btn_down = 1'b0, btn_left = 1'b0;
    logic        sort_active = 1'b0;
    logic        sel_hi_half = 1'b0, sel_hw_count = 1'b0;
    logic [31:0] sw_cycles = '0, hw_cycles = '0;
    logic [7:0]  ram_rdata = '0;
    logic [7:0]  ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [19:0] digit_codes;

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_view_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .btn_up       (btn_up),
        .btn_down     (btn_down),
        .btn_left     (btn_left),
        .sort_active  (sort_active),
        .sel_hi_half  (sel_hi_half),
        .sel_hw_count (sel_hw_count),
        .sw_cycles    (sw_cycles),
        .hw_cycles    (hw_cycles),
        .ram_rdata    (ram_rdata),
        .ram_addr     (ram_addr),
        .ram_we       (ram_we),
        .ram_wdata    (ram_wdata),
        .digit_codes  (digit_codes)
    );

    // external synchronous RAM, one cycle read latency
    logic [7:0] mem [256];
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        ram_rdata <= mem[ram_addr];
    end

    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] gen_m    = 8'h01;
    logic [7:0] exp_addr = 8'h00;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] dig(input int i);
        return digit_codes[5*i +: 5];
    endfunction

    function automatic logic [19:0] all_code(input logic [4:0] c);
        return {c, c, c, c};
    endfunction

    task automatic check_addr_digits(input string req);
        logic [9:0] e;
        e = {1'b0, exp_addr[7:4], 1'b0, exp_addr[3:0]};
        check({dig(3), dig(2)} == e, req, {dig(3), dig(2)}, e);
    endtask

    task automatic check_data_digits(input string req);
        logic [9:0] e;
        e = {1'b0, exp_mem[exp_addr][7:4], 1'b0, exp_mem[exp_addr][3:0]};
        check({dig(1), dig(0)} == e, req, {dig(1), dig(0)}, e);
    endtask

    task automatic step(input bit up, input bit dn, input string req);
        @(negedge clk);
        btn_up = up; btn_down = dn;
        @(negedge clk);
        btn_up = 1'b0; btn_down = 1'b0;
        if (up && !dn)      exp_addr = exp_addr + 8'd1;
        else if (dn && !up) exp_addr = exp_addr - 8'd1;
        check_addr_digits(req);
        @(negedge clk);
        check_data_digits("R2 data digits");
    endtask

    task automatic do_fill(input bit with_up);
        bit wr_ok, blank_ok;
        wr_ok = 1'b1; blank_ok = 1'b1;
        @(negedge clk);
        btn_left = 1'b1; btn_up = with_up;
        @(negedge clk);
        btn_left = 1'b0; btn_up = 1'b0;
        for (int k = 0; k < 256; k++) begin
            if (wr_ok && !(ram_we && ram_addr == 8'(k) && ram_wdata == gen_m)) begin
                wr_ok = 1'b0;
                $display("FAIL R4 fill step %0d actual we=%b addr=%h data=%h expected addr=%h data=%h",
                         k, ram_we, ram_addr, ram_wdata, 8'(k), gen_m);
            end
            if (blank_ok && digit_codes != all_code(5'h11)) begin
                blank_ok = 1'b0;
                $display("FAIL R5 fill digits actual=%h expected=%h", digit_codes, all_code(5'h11));
            end
            exp_mem[k] = gen_m;
            gen_m = (gen_m >> 1) ^ (gen_m[0] ? 8'hB8 : 8'h00);
            if (k == 10) btn_up = 1'b1;
            if (k == 11) btn_up = 1'b0;
            if (k == 20) sort_active = 1'b1;
            if (k == 22) sort_active = 1'b0;
            @(negedge clk);
        end
        n_checks += 2;
        if (!wr_ok)    n_fail++;
        if (!blank_ok) n_fail++;
        check(ram_we == 1'b0, "R4 fill ends after 256 writes", 32'(ram_we), 32'd0);
        check_addr_digits("R5 address kept across fill");
        @(negedge clk);
        check_data_digits("R4 filled byte readback");
    endtask

    task automatic check_count(input string req);
        logic [31:0] v;
        logic [15:0] s;
        v = sel_hw_count ? hw_cycles : sw_cycles;
        s = sel_hi_half ? v[31:16] : v[15:0];
        for (int i = 0; i < 4; i++)
            check(dig(i) == {1'b0, s[4*i +: 4]}, req, 32'(dig(i)), 32'({1'b0, s[4*i +: 4]}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ram_we == 1'b0, "R1 no write in reset", 32'(ram_we), 32'd0);
        rst = 1'b0;
        check(ram_we == 1'b0, "R1 no write after reset", 32'(ram_we), 32'd0);
        check_addr_digits("R1 address zero after reset");

        do_fill(1'b0);

        // R2 R3: full sweep upward across the wrap
        for (int i = 0; i < 256; i++) step(1'b1, 1'b0, "R3 up step");
        // R3: full sweep downward across the wrap
        for (int i = 0; i < 256; i++) step(1'b0, 1'b1, "R3 down step");
        step(1'b1, 1'b1, "R3 up and down together");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R3 up step");

        // R4 R5: second fill, started together with an up pulse
        do_fill(1'b1);
        step(1'b0, 1'b1, "R2 browse after refill");

        // R6: sort start in the same cycle as an up pulse
        @(negedge clk);
        sort_active = 1'b1; btn_up = 1'b1;
        @(negedge clk);
        btn_up = 1'b0;
        check(digit_codes == all_code(5'h10), "R6 dashes while sorting", 32'(digit_codes), 32'(all_code(5'h10)));
        btn_left = 1'b1;
        @(negedge clk);
        btn_left = 1'b0; btn_down = 1'b1;
        @(negedge clk);
        btn_down = 1'b0;
        check(ram_we == 1'b0, "R6 left ignored while sorting", 32'(ram_we), 32'd0);
        check(digit_codes == all_code(5'h10), "R6 dashes hold", 32'(digit_codes), 32'(all_code(5'h10)));
        sw_cycles = 32'h1234_ABCD;
        hw_cycles = 32'h0F0E_5A69;
        sort_active = 1'b0;
        @(negedge clk);
        // R7 R8: every switch combination
        for (int c = 0; c < 4; c++) begin
            sel_hi_half = c[0]; sel_hw_count = c[1];
            #1;
            check_count("R8 count slice select");
        end
        sel_hi_half = 1'b0; sel_hw_count = 1'b0;
        #1;
        check_count("R7 count view");

        // R9: down pulse leaves the count view
        @(negedge clk);
        btn_down = 1'b1;
        @(negedge clk);
        btn_down = 1'b0;
        check_addr_digits("R9 address kept on exit");
        @(negedge clk);
        check_data_digits("R9 browse data after exit");

        // R6 from count view, then R9 with a left pulse
        @(negedge clk);
        sort_active = 1'b1;
        @(negedge clk);
        sort_active = 1'b0;
        @(negedge clk);
        check_count("R7 count view after second sort");
        @(negedge clk);
        sort_active = 1'b1;
        @(negedge clk);
        check(digit_codes == all_code(5'h10), "R6 sort from count view", 32'(digit_codes), 32'(all_code(5'h10)));
        sort_active = 1'b0;
        @(negedge clk);
        btn_left = 1'b1;
        @(negedge clk);
        btn_left = 1'b0;
        check(ram_we == 1'b0, "R9 left exits without fill", 32'(ram_we), 32'd0);
        check_addr_digits("R9 address kept on left exit");
        @(negedge clk);
        check(ram_we == 1'b0, "R9 still no fill", 32'(ram_we), 32'd0);
        check_data_digits("R9 browse data after left exit");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule